// File: doc/BRIEF.md
# Pixel Unpacker with Grayscale Palette

This block sits between the video-memory fetch path and the panel timing generator of a display controller. It takes one packed 32-bit video word at a time over a valid/ready handshake, then hands out one pixel per request from the timing generator. Each pixel comes out as a 4-bit physical gray level. Three packing modes exist. In monochrome mode each bit is one on/off pixel and goes straight to full black or full white. In the two grayscale modes the 2-bit or 4-bit logical value is translated through a programmable 16-entry palette.

The palette is a 64-bit table of sixteen 4-bit gray levels, written and read as two 32-bit words. Entry k gives the gray level for logical value k. The mode in force for a word is captured when that word is accepted. The palette is consulted when each pixel is emitted, so software can retune gray levels while the display is running.

Top module: `gray_unpacker`

## Requirements
- R1: After reset, in_ready is 1, pix_valid is 0, and both palette words read as 32'h0.
- R2: A write with pal_wr_en=1 stores pal_wr_data into palette word pal_wr_sel (0 = low word, 1 = high word), and pal_rd_data shows it from the next cycle. Low-word bits [4k+3:4k] hold entry k for k = 0..7. High-word bits [4k+3:4k] hold entry 8+k.
- R3: in_ready is 1 exactly when no pixel of the current word is still pending. A word is taken on a clock edge where in_valid and in_ready are both 1, and in_ready is 0 from the next cycle until the edge that emits the word's last pixel.
- R4: With gray_en=0 (monochrome), a word yields 32 pixels starting at bit 0. A bit of 1 is output as level 4'hF and a bit of 0 as 4'h0, and the palette is not used.
- R5: With gray_en=1 and gray_4bpp=0, a word yields 16 pixels taken from bits [1:0] upward. Each pixel is output as palette entry 0..3 for its value.
- R6: With gray_en=1 and gray_4bpp=1, a word yields 8 pixels taken from bits [3:0] upward. Each pixel is output as palette entry 0..15 for its value, with entries 8..15 taken from the high word.
- R7: gray_4bpp has no effect while gray_en=0.
- R8: When pix_req is 1 at a clock edge and a pixel is pending, pix_valid is 1 for the following cycle and pix_out carries that pixel. When pix_req is 0 or nothing is pending, pix_valid is 0 and no pixel is consumed.
- R9: The packing mode is sampled when a word is accepted. Changes to gray_en or gray_4bpp while the word drains do not affect the word's remaining pixels.
- R10: The palette lookup for a pixel uses the palette contents at the clock edge that emits the pixel. A palette write on that same edge applies to later pixels only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Packed video word |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block can take a word |
| gray_en | input | 1 | 1 = grayscale through palette, 0 = monochrome |
| gray_4bpp | input | 1 | 1 = 4 bits per pixel, 0 = 2 bits per pixel |
| pal_wr_en | input | 1 | Palette word write strobe |
| pal_wr_sel | input | 1 | Palette word to write (0 low, 1 high) |
| pal_wr_data | input | 32 | Palette write data |
| pal_rd_sel | input | 1 | Palette word to read |
| pal_rd_data | output | 32 | Selected palette word |
| pix_req | input | 1 | Pixel request from the timing generator |
| pix_out | output | 4 | Physical gray level |
| pix_valid | output | 1 | pix_out holds a new pixel this cycle |

## Verification
The bench targets the word boundary. A design that raised in_ready one pixel early would drop the final pixel or overwrite it with the next word. One that raised it one pixel late would stall the stream. Mode bits are toggled on every cycle while words drain, which catches a design that reads the live mode instead of the captured one: the pixel count and bit slicing of the word would shift mid-word. Random palette writes during emission, including writes on the emitting edge, catch lookups that are stale or a cycle early. Monochrome words sent with gray_4bpp set expose any design that lets the palette or the bit-depth select leak into the direct path.

// File: rtl/gup_pkg.sv
package gup_pkg;

  // Packing mode captured with each video word.
  typedef enum logic [1:0] {
    GUP_MONO = 2'd0,
    GUP_G2   = 2'd1,
    GUP_G4   = 2'd2
  } gup_mode_e;

  function automatic gup_mode_e gup_decode(input logic en, input logic deep);
    if (!en)      return GUP_MONO;
    else if (deep) return GUP_G4;
    else          return GUP_G2;
  endfunction

endpackage

// File: rtl/gup_palette.sv
module gup_palette #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LVL_W-1:0]  lut_idx,
  output logic [LVL_W-1:0]  lut_lvl
);

  localparam int ENTRIES  = 1 << LVL_W;
  localparam int PER_WORD = DATA_W / LVL_W;
  localparam int N_WORDS  = ENTRIES / PER_WORD;

  wire [ENTRIES-1:0][LVL_W-1:0] entries;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              word_we;

    always_comb begin
      word_we = wr_en && (wr_sel == SEL_W'(g));
      word_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_we) word_q <= word_d;
    end

    assign entries[g*PER_WORD +: PER_WORD] = word_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = entries[i*PER_WORD +: PER_WORD];
    end
  end

  assign lut_lvl = entries[lut_idx];

endmodule

// File: rtl/gup_shifter.sv
module gup_shifter
  import gup_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  gup_mode_e         mode_in,
  input  logic              pix_req,
  output logic              emit,
  output logic [LVL_W-1:0]  raw_pix,
  output gup_mode_e         mode_q
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] N_MONO = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_G2   = CNT_W'(DATA_W / 2);
  localparam logic [CNT_W-1:0] N_G4   = CNT_W'(DATA_W / LVL_W);

  logic [DATA_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  left_q, left_d;
  gup_mode_e         mode_d;
  logic              pending, accept, load_en;

  assign pending  = (left_q != '0);
  assign in_ready = !pending;
  assign accept   = in_valid && !pending;
  assign emit     = pix_req && pending;
  assign load_en  = accept || emit;
  assign raw_pix  = word_q[LVL_W-1:0];

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    mode_d = mode_q;
    if (accept) begin
      word_d = in_data;
      mode_d = mode_in;
      case (mode_in)
        GUP_MONO: left_d = N_MONO;
        GUP_G2:   left_d = N_G2;
        default:  left_d = N_G4;
      endcase
    end else if (emit) begin
      left_d = left_q - 1'b1;
      case (mode_q)
        GUP_MONO: word_d = word_q >> 1;
        GUP_G2:   word_d = word_q >> 2;
        default:  word_d = word_q >> LVL_W;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
      mode_q <= GUP_MONO;
    end else if (load_en) begin
      word_q <= word_d;
      left_q <= left_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/gup_mapper.sv
module gup_mapper
  import gup_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  gup_mode_e        mode,
  input  logic [LVL_W-1:0] raw_pix,
  output logic [LVL_W-1:0] lut_idx,
  input  logic [LVL_W-1:0] lut_lvl,
  output logic [LVL_W-1:0] level
);

  always_comb begin
    case (mode)
      GUP_MONO: begin
        lut_idx = '0;
        level   = {LVL_W{raw_pix[0]}};
      end
      GUP_G2: begin
        lut_idx = LVL_W'(raw_pix[1:0]);
        level   = lut_lvl;
      end
      default: begin
        lut_idx = raw_pix;
        level   = lut_lvl;
      end
    endcase
  end

endmodule

// File: rtl/gray_unpacker.sv
module gray_unpacker
  import gup_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4,
  localparam int PSEL_W = ((1 << LVL_W) * LVL_W / DATA_W) > 1 ?
                          $clog2((1 << LVL_W) * LVL_W / DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              gray_en,
  input  logic              gray_4bpp,
  input  logic              pal_wr_en,
  input  logic [PSEL_W-1:0] pal_wr_sel,
  input  logic [DATA_W-1:0] pal_wr_data,
  input  logic [PSEL_W-1:0] pal_rd_sel,
  output logic [DATA_W-1:0] pal_rd_data,
  input  logic              pix_req,
  output logic [LVL_W-1:0]  pix_out,
  output logic              pix_valid
);

  gup_mode_e        mode_in;
  gup_mode_e        act_mode;
  logic             emit;
  logic [LVL_W-1:0] raw_pix, lut_idx, lut_lvl, level;
  logic [LVL_W-1:0] pix_out_d;
  logic             pix_valid_d;

  assign mode_in = gup_decode(gray_en, gray_4bpp);

  gup_shifter #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mode_in  (mode_in),
    .pix_req  (pix_req),
    .emit     (emit),
    .raw_pix  (raw_pix),
    .mode_q   (act_mode)
  );

  gup_mapper #(.LVL_W(LVL_W)) u_map (
    .mode    (act_mode),
    .raw_pix (raw_pix),
    .lut_idx (lut_idx),
    .lut_lvl (lut_lvl),
    .level   (level)
  );

  gup_palette #(.DATA_W(DATA_W), .LVL_W(LVL_W), .SEL_W(PSEL_W)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pal_wr_en),
    .wr_sel  (pal_wr_sel),
    .wr_data (pal_wr_data),
    .rd_sel  (pal_rd_sel),
    .rd_data (pal_rd_data),
    .lut_idx (lut_idx),
    .lut_lvl (lut_lvl)
  );

  always_comb begin
    pix_valid_d = emit;
    pix_out_d   = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      pix_valid <= pix_valid_d;
      if (emit) pix_out <= pix_out_d;
    end
  end

endmodule

// File: rtl/gup_chk.sv
module gup_chk
  import gup_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4,
  parameter int PSEL_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              pix_req,
  input logic              pix_valid,
  input logic [LVL_W-1:0]  pix_out,
  input gup_mode_e         act_mode,
  input logic              pal_wr_en,
  input logic [PSEL_W-1:0] pal_wr_sel,
  input logic [DATA_W-1:0] pal_wr_data,
  input logic [PSEL_W-1:0] pal_rd_sel,
  input logic [DATA_W-1:0] pal_rd_data
);

  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pix_req) |=> !in_ready);

  // R8
  valid_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_req && !in_ready));

  // R4
  mono_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && act_mode == GUP_MONO) |-> (pix_out == '0 || pix_out == '1));

  // R2
  pal_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr_en |=> (pal_rd_sel != $past(pal_wr_sel)) || (pal_rd_data == $past(pal_wr_data)));

endmodule

bind gray_unpacker gup_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W), .PSEL_W(PSEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .pix_req     (pix_req),
  .pix_valid   (pix_valid),
  .pix_out     (pix_out),
  .act_mode    (act_mode),
  .pal_wr_en   (pal_wr_en),
  .pal_wr_sel  (pal_wr_sel),
  .pal_wr_data (pal_wr_data),
  .pal_rd_sel  (pal_rd_sel),
  .pal_rd_data (pal_rd_data)
);

// File: tb/gray_unpacker_tb.sv
`timescale 1ns/1ps
module gray_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic        gray_en, gray_4bpp;
  logic        pal_wr_en, pal_wr_sel, pal_rd_sel;
  logic [31:0] pal_wr_data, pal_rd_data;
  logic        pix_req;
  logic [3:0]  pix_out;
  logic        pix_valid;

  always #2.5 clk = ~clk;

  gray_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .gray_en(gray_en), .gray_4bpp(gray_4bpp),
    .pal_wr_en(pal_wr_en), .pal_wr_sel(pal_wr_sel), .pal_wr_data(pal_wr_data),
    .pal_rd_sel(pal_rd_sel), .pal_rd_data(pal_rd_data), .pix_req(pix_req),
    .pix_out(pix_out), .pix_valid(pix_valid)
  );

  // ---------------- behavioural reference ----------------
  int          q[$];
  int          m_bpp;
  logic [31:0] m_pal [2];
  bit          m_valid;
  logic [3:0]  m_out;

  function automatic logic [3:0] ref_level(int v, int bpp);
    if (bpp == 1) return (v != 0) ? 4'hF : 4'h0;
    if (v < 8) return m_pal[0][4*v +: 4];
    return m_pal[1][4*(v-8) +: 4];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit empty0;
    if (!rst_n) begin
      q.delete();
      m_bpp = 1; m_valid = 0; m_out = '0;
      m_pal[0] = '0; m_pal[1] = '0;
    end else begin
      empty0  = (q.size() == 0);
      m_valid = 0;
      if (!empty0 && pix_req) begin
        m_out   = ref_level(q.pop_front(), m_bpp);
        m_valid = 1;
      end
      if (empty0 && in_valid) begin
        m_bpp = !gray_en ? 1 : (gray_4bpp ? 4 : 2);
        for (int i = 0; i < 32 / m_bpp; i++)
          q.push_back(int'((in_data >> (i * m_bpp)) & ((32'd1 << m_bpp) - 1)));
      end
      if (pal_wr_en) m_pal[pal_wr_sel] = pal_wr_data;
    end
  end

  // ---------------- checking ----------------
  int    n_vec = 0, n_bad = 0;
  string phase = "R1";
  bit    done  = 0;
  int    p_req = 100, p_val = 100;
  bit    flip_mode = 0, rand_pal = 0, cfg_en = 0, cfg_4 = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    string mtag;
    mtag = (m_bpp == 1) ? "R4 mono level" : (m_bpp == 2) ? "R5 2bpp level" : "R6 4bpp level";
    chk("R3 in_ready", 32'(in_ready), 32'(q.size() == 0));
    chk("R8 pix_valid", 32'(pix_valid), 32'(m_valid));
    if (m_valid && pix_valid) chk(mtag, 32'(pix_out), 32'(m_out));
    chk("R2 pal_rd_data", pal_rd_data, m_pal[pal_rd_sel]);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      step();
      in_valid = (($urandom % 100) < p_val);
      in_data  = $urandom;
      pix_req  = (($urandom % 100) < p_req);
      if (flip_mode) begin
        gray_en   = $urandom % 2;
        gray_4bpp = $urandom % 2;
      end else begin
        gray_en   = cfg_en;
        gray_4bpp = cfg_4;
      end
      pal_wr_en   = rand_pal && (($urandom % 4) == 0);
      pal_wr_sel  = $urandom % 2;
      pal_wr_data = $urandom;
      pal_rd_sel  = $urandom % 2;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_data = '0; in_valid = 0; gray_en = 0; gray_4bpp = 0;
    pal_wr_en = 0; pal_wr_sel = 0; pal_wr_data = '0; pal_rd_sel = 0; pix_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    phase = "R1";
    step();
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 pix_valid", 32'(pix_valid), 32'd0);
    chk("R1 pal low", pal_rd_data, 32'h0);
    pal_rd_sel = 1;
    step();
    chk("R1 pal high", pal_rd_data, 32'h0);

    // R2: palette write and read back of both words
    phase = "R2";
    pal_wr_en = 1; pal_wr_sel = 0; pal_wr_data = 32'h9E3C_51A7; pal_rd_sel = 0;
    step();
    chk("R2 low word", pal_rd_data, 32'h9E3C_51A7);
    pal_wr_sel = 1; pal_wr_data = 32'h0F84_D26B; pal_rd_sel = 1;
    step();
    chk("R2 high word", pal_rd_data, 32'h0F84_D26B);
    pal_wr_en = 0; pal_rd_sel = 0;
    step();
    chk("R2 low kept", pal_rd_data, 32'h9E3C_51A7);

    // R4: monochrome, continuous requests
    phase = "R4"; cfg_en = 0; cfg_4 = 0; p_req = 100; p_val = 100;
    run(400);
    // R7: depth select set while grayscale off
    phase = "R7"; cfg_4 = 1;
    run(300);
    // R5: 2 bits per pixel
    phase = "R5"; cfg_en = 1; cfg_4 = 0;
    run(400);
    // R6: 4 bits per pixel, high palette word used
    phase = "R6"; cfg_4 = 1;
    run(400);
    // R8: sparse requests and sparse words, including requests while empty
    phase = "R8"; p_req = 30; p_val = 20;
    run(600);
    // R3: word boundary with words always offered
    phase = "R3"; p_req = 70; p_val = 100; cfg_4 = 0;
    run(400);
    // R9: mode bits toggled every cycle while words drain
    phase = "R9"; flip_mode = 1; p_req = 80;
    run(800);
    // R10: palette rewritten while pixels are being emitted
    phase = "R10"; flip_mode = 0; cfg_en = 1; cfg_4 = 1; rand_pal = 1;
    run(800);
    rand_pal = 1; flip_mode = 1;
    run(400);

    done = 1;
    summary();
    $finish;
  end

endmodule